// File: doc/BRIEF.md
# Ethernet PHY Bring-Up Sequencer

This block brings an external Ethernet PHY into service after reset. It does not talk to the PHY pins itself. Instead it issues register read and write requests to a separate management-bus master, and that master does the serial framing and produces the management clock. On a start pulse the sequencer first reads the PHY control register. It writes the control register back with internal loopback cleared and automatic speed/duplex negotiation enabled. It then polls the status register in two phases: first until negotiation is reported complete, then until the link is reported up. When the link is up it reads the link partner's ability register once and holds that value on an output.

Each poll of the status register comes after a fixed idle gap. Each polling phase stops after a maximum number of reads. If a phase runs out of reads, the block raises an error flag, reports which phase failed, and returns to idle. The PHY address is sampled at start, so one sequencer can serve any PHY on a shared management bus. A clock divisor parameter is passed straight to the master so that the master keeps its clock at or below 2.5 MHz.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset `cmd_req`, `link_up`, `init_done` and `err` are low and `err_code` is 0. `mdc_div` always equals the `MDC_DIV` parameter (default 224).
- R2: A start pulse in idle samples `phy_addr`. The first access is a read of register 0, the second is a write of register 0. Every access carries the sampled address on `cmd_phy`.
- R3: While `cmd_req` is high and `cmd_done` is low, the request and all its fields stay unchanged. In the cycle after `cmd_done`, `cmd_req` is low, so at most one access is outstanding.
- R4: The register 0 write data equals the value read from register 0 with bit 14 (loopback) cleared and bit 12 (negotiation enable) set. All other bits are unchanged.
- R5: After the write, the block reads register 1 until bit 5 (mask 0x0020, negotiation complete) is set. Before every read of register 1, `cmd_req` is low for exactly `POLL_GAP` cycles.
- R6: After negotiation completes, the block reads register 1 again until bit 2 (mask 0x0004, link status) is set. It asserts `link_up` only then. Bit 2 seen during the negotiation phase has no effect.
- R7: After link-up the block reads register 5 exactly once, presents the value on `partner_abil`, and asserts `init_done`.
- R8: If `MAX_POLLS` reads in one phase fail, the block sets `err` and returns to idle without further requests. `err_code` is 2'b01 for the negotiation phase and 2'b10 for the link phase, and it is 0 whenever `err` is low.
- R9: A start pulse while a sequence runs is ignored. Register 0 is read only once and the run ends as it would have without the pulse.
- R10: A start pulse after completion or error clears `link_up`, `init_done`, `err` and `err_code` in the next cycle and restarts from the register 0 read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle start pulse |
| phy_addr | input | 5 | Target PHY address, sampled at start |
| cmd_req | output | 1 | Access request to the management master |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_phy | output | 5 | PHY address of the access |
| cmd_reg | output | 5 | Register number of the access |
| cmd_wdata | output | 16 | Write data |
| cmd_done | input | 1 | One-cycle completion strobe from the master |
| cmd_rdata | input | 16 | Read data, valid with `cmd_done` |
| mdc_div | output | 8 | Management clock divisor for the master |
| link_up | output | 1 | Link reported up |
| init_done | output | 1 | Whole sequence finished |
| err | output | 1 | A polling phase timed out |
| err_code | output | 2 | Failed phase: 01 negotiation, 10 link |
| partner_abil | output | 16 | Latched link partner ability word |

## Verification
The bench builds the block with `POLL_GAP` = 3 and `MAX_POLLS` = 4. With these values the exact idle gap before each poll can be counted, and both timeouts can be reached in a few dozen cycles. The PHY model draws the number of reads each phase needs from 1 to 5. This covers completion on the first poll, completion on exactly the last allowed poll, and one read beyond the limit in either phase. The master's response latency and the control and partner words are random, and directed runs cover the control values with every bit set and with only bit 14 set.

// File: rtl/phy_bringup_pkg.sv
// Shared constants and types for the PHY bring-up sequencer.
// Assumes the standard management register layout: control at 0,
// status at 1, partner ability at 5.
package phy_bringup_pkg;

    localparam int DATA_W = 16;
    localparam int REG_W  = 5;

    localparam logic [REG_W-1:0] REG_CTRL    = 5'd0;
    localparam logic [REG_W-1:0] REG_STATUS  = 5'd1;
    localparam logic [REG_W-1:0] REG_PARTNER = 5'd5;

    localparam logic [DATA_W-1:0] MASK_LOOPBACK = 16'h4000;
    localparam logic [DATA_W-1:0] MASK_ANEG_EN  = 16'h1000;
    localparam logic [DATA_W-1:0] MASK_ANEG_OK  = 16'h0020;
    localparam logic [DATA_W-1:0] MASK_LINK_OK  = 16'h0004;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_CTRL,
        ST_MOD_CTRL,
        ST_WR_CTRL,
        ST_AN_GAP,
        ST_AN_RD,
        ST_LK_GAP,
        ST_LK_RD,
        ST_LK_HOLD,
        ST_RD_PART
    } seq_state_t;

    typedef enum logic [1:0] {
        FAIL_NONE = 2'b00,
        FAIL_ANEG = 2'b01,
        FAIL_LINK = 2'b10
    } fail_code_t;

endpackage

// File: rtl/phy_bringup_gap_timer.sv
// Down-counter that holds the sequencer in a wait state for GAP_CYCLES
// cycles. Assumes GAP_CYCLES >= 1; load restarts the interval.
module phy_bringup_gap_timer #(
    parameter int GAP_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(GAP_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on gap entry, then count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/phy_bringup_poll_ctr.sv
// Counts failed status reads within one polling phase. It flags when the
// read in progress is the last one allowed. Assumes MAX_POLLS >= 1.
module phy_bringup_poll_ctr #(
    parameter int MAX_POLLS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic incr,
    output logic last_poll
);
    localparam int CNT_W = $clog2(MAX_POLLS + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_POLLS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Reset the count at phase entry; advance once per failed read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (incr)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last_poll = (cnt_q == LAST_IDX);
endmodule

// File: rtl/phy_bringup_fsm.sv
// Control state machine of the bring-up sequence. It issues one access at
// a time and waits for the master's done strobe before moving on. After
// every completed access it leaves the request low for at least one cycle.
// Assumes cmd_done is a one-cycle strobe that comes only while cmd_req is high.
module phy_bringup_fsm
    import phy_bringup_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [4:0]        phy_addr,
    input  logic              cmd_done,
    input  logic [DATA_W-1:0] cmd_rdata,
    input  logic              gap_expired,
    input  logic              last_poll,
    output logic              gap_load,
    output logic              poll_clear,
    output logic              poll_incr,
    output logic              cmd_req,
    output logic              cmd_write,
    output logic [4:0]        cmd_phy,
    output logic [REG_W-1:0]  cmd_reg,
    output logic [DATA_W-1:0] cmd_wdata,
    output logic              link_up,
    output logic              init_done,
    output logic              err,
    output logic [1:0]        err_code,
    output logic [DATA_W-1:0] partner_abil
);
    seq_state_t        st_q, st_nxt;
    logic [4:0]        addr_q;
    logic [DATA_W-1:0] ctrl_q;
    logic              aneg_ok, link_ok;

    assign aneg_ok = |(cmd_rdata & MASK_ANEG_OK);
    assign link_ok = |(cmd_rdata & MASK_LINK_OK);

    // Next-state decision and the strobes for the timer and poll counter.
    always_comb begin
        st_nxt     = st_q;
        gap_load   = 1'b0;
        poll_clear = 1'b0;
        poll_incr  = 1'b0;
        case (st_q)
            ST_IDLE:     if (start) st_nxt = ST_RD_CTRL;
            ST_RD_CTRL:  if (cmd_done) st_nxt = ST_MOD_CTRL;
            ST_MOD_CTRL: st_nxt = ST_WR_CTRL;
            ST_WR_CTRL: if (cmd_done) begin
                st_nxt     = ST_AN_GAP;
                gap_load   = 1'b1;
                poll_clear = 1'b1;
            end
            ST_AN_GAP:   if (gap_expired) st_nxt = ST_AN_RD;
            ST_AN_RD: if (cmd_done) begin
                if (aneg_ok) begin
                    st_nxt     = ST_LK_GAP;
                    gap_load   = 1'b1;
                    poll_clear = 1'b1;
                end else if (last_poll) begin
                    st_nxt = ST_IDLE;
                end else begin
                    st_nxt    = ST_AN_GAP;
                    gap_load  = 1'b1;
                    poll_incr = 1'b1;
                end
            end
            ST_LK_GAP:   if (gap_expired) st_nxt = ST_LK_RD;
            ST_LK_RD: if (cmd_done) begin
                if (link_ok) begin
                    st_nxt = ST_LK_HOLD;
                end else if (last_poll) begin
                    st_nxt = ST_IDLE;
                end else begin
                    st_nxt    = ST_LK_GAP;
                    gap_load  = 1'b1;
                    poll_incr = 1'b1;
                end
            end
            ST_LK_HOLD:  st_nxt = ST_RD_PART;
            ST_RD_PART:  if (cmd_done) st_nxt = ST_IDLE;
            default:     st_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // Sampled address, modified control word and the result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q       <= '0;
            ctrl_q       <= '0;
            link_up      <= 1'b0;
            init_done    <= 1'b0;
            err          <= 1'b0;
            err_code     <= FAIL_NONE;
            partner_abil <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) begin
                    addr_q    <= phy_addr;
                    link_up   <= 1'b0;
                    init_done <= 1'b0;
                    err       <= 1'b0;
                    err_code  <= FAIL_NONE;
                end
                ST_RD_CTRL: if (cmd_done)
                    ctrl_q <= (cmd_rdata & ~MASK_LOOPBACK) | MASK_ANEG_EN;
                ST_AN_RD: if (cmd_done && !aneg_ok && last_poll) begin
                    err      <= 1'b1;
                    err_code <= FAIL_ANEG;
                end
                ST_LK_RD: if (cmd_done) begin
                    if (link_ok) begin
                        link_up <= 1'b1;
                    end else if (last_poll) begin
                        err      <= 1'b1;
                        err_code <= FAIL_LINK;
                    end
                end
                ST_RD_PART: if (cmd_done) begin
                    partner_abil <= cmd_rdata;
                    init_done    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Request fields decoded from the current state.
    always_comb begin
        cmd_req   = 1'b0;
        cmd_write = 1'b0;
        cmd_reg   = REG_CTRL;
        cmd_wdata = '0;
        case (st_q)
            ST_RD_CTRL: cmd_req = 1'b1;
            ST_WR_CTRL: begin
                cmd_req   = 1'b1;
                cmd_write = 1'b1;
                cmd_wdata = ctrl_q;
            end
            ST_AN_RD, ST_LK_RD: begin
                cmd_req = 1'b1;
                cmd_reg = REG_STATUS;
            end
            ST_RD_PART: begin
                cmd_req = 1'b1;
                cmd_reg = REG_PARTNER;
            end
            default: ;
        endcase
    end

    assign cmd_phy = addr_q;
endmodule

// File: rtl/phy_bringup_seq.sv
// Top of the PHY bring-up sequencer. It wires the control FSM to the poll
// gap timer and the per-phase poll counter, and drives the fixed clock
// divisor to the management master. Assumes the master handles framing.
module phy_bringup_seq #(
    parameter int POLL_GAP  = 1000,
    parameter int MAX_POLLS = 1000,
    parameter int MDC_DIV   = 224,
    parameter int DIV_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [4:0]       phy_addr,
    output logic             cmd_req,
    output logic             cmd_write,
    output logic [4:0]       cmd_phy,
    output logic [4:0]       cmd_reg,
    output logic [15:0]      cmd_wdata,
    input  logic             cmd_done,
    input  logic [15:0]      cmd_rdata,
    output logic [DIV_W-1:0] mdc_div,
    output logic             link_up,
    output logic             init_done,
    output logic             err,
    output logic [1:0]       err_code,
    output logic [15:0]      partner_abil
);
    logic gap_load, gap_expired, poll_clear, poll_incr, last_poll;

    phy_bringup_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .phy_addr     (phy_addr),
        .cmd_done     (cmd_done),
        .cmd_rdata    (cmd_rdata),
        .gap_expired  (gap_expired),
        .last_poll    (last_poll),
        .gap_load     (gap_load),
        .poll_clear   (poll_clear),
        .poll_incr    (poll_incr),
        .cmd_req      (cmd_req),
        .cmd_write    (cmd_write),
        .cmd_phy      (cmd_phy),
        .cmd_reg      (cmd_reg),
        .cmd_wdata    (cmd_wdata),
        .link_up      (link_up),
        .init_done    (init_done),
        .err          (err),
        .err_code     (err_code),
        .partner_abil (partner_abil)
    );

    phy_bringup_gap_timer #(.GAP_CYCLES(POLL_GAP)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .expired (gap_expired)
    );

    phy_bringup_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_polls (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (poll_clear),
        .incr      (poll_incr),
        .last_poll (last_poll)
    );

    assign mdc_div = DIV_W'(MDC_DIV);
endmodule

// File: rtl/phy_bringup_seq_chk.sv
// Protocol and result checker for phy_bringup_seq, bound to every instance.
// It observes ports only.
module phy_bringup_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_req,
    input logic        cmd_write,
    input logic [4:0]  cmd_phy,
    input logic [4:0]  cmd_reg,
    input logic [15:0] cmd_wdata,
    input logic        cmd_done,
    input logic [15:0] cmd_rdata,
    input logic        link_up,
    input logic        init_done,
    input logic        err,
    input logic [1:0]  err_code
);
    // R3: a pending request holds all of its fields.
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && !cmd_done |=> cmd_req && $stable(cmd_reg) && $stable(cmd_write)
                                 && $stable(cmd_phy) && $stable(cmd_wdata));

    // R3: the request drops after completion.
    assert_req_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && cmd_done |=> !cmd_req);

    // R4: control writes clear loopback and enable negotiation.
    assert_ctrl_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && cmd_write |-> cmd_reg == 5'd0 && !cmd_wdata[14] && cmd_wdata[12]);

    // R6: link-up follows a status read that showed the link bit.
    assert_link_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(cmd_done && cmd_reg == 5'd1 && cmd_rdata[2]));

    // R7: completion implies link and no error.
    assert_done_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> link_up && !err);

    // R8: the error code is non-zero exactly when the error flag is set.
    assert_err_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err == (err_code != 2'b00));

    // R8: no requests while an error is held.
    assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !cmd_req);
endmodule

bind phy_bringup_seq phy_bringup_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_req   (cmd_req),
    .cmd_write (cmd_write),
    .cmd_phy   (cmd_phy),
    .cmd_reg   (cmd_reg),
    .cmd_wdata (cmd_wdata),
    .cmd_done  (cmd_done),
    .cmd_rdata (cmd_rdata),
    .link_up   (link_up),
    .init_done (init_done),
    .err       (err),
    .err_code  (err_code)
);

// File: tb/phy_bringup_seq_tb.sv
module phy_bringup_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int POLL_GAP   = 3;
    localparam int MAX_POLLS  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic        cmd_req, cmd_write;
    logic [4:0]  cmd_phy, cmd_reg;
    logic [15:0] cmd_wdata;
    logic        cmd_done = 1'b0;
    logic [15:0] cmd_rdata = '0;
    logic [7:0]  mdc_div;
    logic        link_up, init_done, err;
    logic [1:0]  err_code;
    logic [15:0] partner_abil;

    int n_checks = 0;
    int n_errs   = 0;

    // PHY model settings for the current run
    int          an_need, lk_need, lat;
    logic [15:0] ctrl_val, part_val;
    logic [4:0]  exp_addr;
    // observations made by the model
    int          r0_reads, r0_writes, r1_reads, r5_reads, other_acc;
    int          gap_bad, stab_bad, phy_bad, order_bad, acc_idx, idle_cnt, wait_cnt;
    logic [15:0] wr_seen;
    bit          in_req;
    logic [4:0]  cap_reg, cap_phy;
    logic        cap_wr;
    logic [15:0] cap_wd;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_bringup_seq #(.POLL_GAP(POLL_GAP), .MAX_POLLS(MAX_POLLS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .phy_addr(phy_addr),
        .cmd_req(cmd_req), .cmd_write(cmd_write), .cmd_phy(cmd_phy),
        .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .cmd_done(cmd_done),
        .cmd_rdata(cmd_rdata), .mdc_div(mdc_div), .link_up(link_up),
        .init_done(init_done), .err(err), .err_code(err_code),
        .partner_abil(partner_abil));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Status word the PHY model returns for the n-th status read of a run.
    function automatic logic [15:0] status_word(input int n);
        logic [15:0] v;
        v = 16'($urandom) & ~16'h0024;
        if (n < an_need)       v = v | (16'($urandom) & 16'h0004);
        else if (n == an_need) v = v | 16'h0020;
        else begin
            v = v | 16'h0020;
            if (n - an_need >= lk_need) v = v | 16'h0004;
        end
        return v;
    endfunction

    // Behavioral management master plus PHY register model, driven at negedge.
    always @(negedge clk) begin
        if (!rst_n) begin
            cmd_done = 1'b0;
            in_req   = 1'b0;
            idle_cnt = 0;
        end else if (cmd_done) begin
            cmd_done = 1'b0;
            in_req   = 1'b0;
            if (!cmd_req) idle_cnt++;
        end else if (cmd_req) begin
            if (!in_req) begin
                in_req = 1'b1;
                wait_cnt = 0;
                cap_reg = cmd_reg; cap_phy = cmd_phy; cap_wr = cmd_write; cap_wd = cmd_wdata;
                if (cmd_reg == 5'd1 && idle_cnt != POLL_GAP) gap_bad++;
                if (cmd_phy != exp_addr) phy_bad++;
                if (acc_idx == 0 && (cmd_reg != 5'd0 || cmd_write)) order_bad++;
                if (acc_idx == 1 && (cmd_reg != 5'd0 || !cmd_write)) order_bad++;
                acc_idx++;
            end else if (cmd_reg != cap_reg || cmd_phy != cap_phy ||
                         cmd_write != cap_wr || cmd_wdata != cap_wd) begin
                stab_bad++;
            end
            idle_cnt = 0;
            if (wait_cnt >= lat) begin
                cmd_done = 1'b1;
                cmd_rdata = 16'($urandom);
                if (cmd_write) begin
                    if (cmd_reg == 5'd0) begin r0_writes++; wr_seen = cmd_wdata; end
                    else other_acc++;
                end else if (cmd_reg == 5'd0) begin
                    r0_reads++; cmd_rdata = ctrl_val;
                end else if (cmd_reg == 5'd1) begin
                    r1_reads++; cmd_rdata = status_word(r1_reads);
                end else if (cmd_reg == 5'd5) begin
                    r5_reads++; cmd_rdata = part_val;
                end else other_acc++;
            end else wait_cnt++;
        end else idle_cnt++;
    end

    task automatic run_seq(input int an_n, input int lk_n, input int lt,
                           input logic [15:0] c, input logic [15:0] p,
                           input logic [4:0] a, input bit mid_start);
        int   cyc;
        int   exp_r1;
        bit   exp_ok;
        logic [1:0] exp_code;
        an_need = an_n; lk_need = lk_n; lat = lt; ctrl_val = c; part_val = p;
        exp_addr = a;
        r0_reads = 0; r0_writes = 0; r1_reads = 0; r5_reads = 0; other_acc = 0;
        gap_bad = 0; stab_bad = 0; phy_bad = 0; order_bad = 0; acc_idx = 0;
        wr_seen = '0;
        @(negedge clk); phy_addr = a; start = 1'b1;
        @(negedge clk); start = 1'b0; phy_addr = ~a;
        // R10: flags cleared in the cycle after start
        chk(!err && !init_done && !link_up && err_code == 2'b00, "R10", "flags clear after start",
            {err, init_done, link_up, err_code}, 0);
        if (mid_start) begin
            repeat (6) @(negedge clk);
            start = 1'b1;                        // R9: must be ignored
            @(negedge clk); start = 1'b0;
        end
        cyc = 0;
        while (!init_done && !err && cyc < 2000) begin @(negedge clk); cyc++; end
        chk(cyc < 2000, "R7", "sequence ended", cyc, 0);
        repeat (4) @(negedge clk);

        exp_code = 2'b00; exp_ok = 1'b1;
        if (an_n > MAX_POLLS) begin exp_ok = 0; exp_code = 2'b01; exp_r1 = MAX_POLLS; end
        else if (lk_n > MAX_POLLS) begin exp_ok = 0; exp_code = 2'b10; exp_r1 = an_n + MAX_POLLS; end
        else exp_r1 = an_n + lk_n;

        chk(r0_reads == 1, "R9", "register 0 reads", r0_reads, 1);
        chk(order_bad == 0 && phy_bad == 0, "R2", "access order and PHY address",
            order_bad + phy_bad, 0);
        chk(stab_bad == 0 && !cmd_req, "R3", "request stable until done", stab_bad, 0);
        chk(r0_writes == 1 && wr_seen == ((c & ~16'h4000) | 16'h1000), "R4",
            "control write data", wr_seen, (c & ~16'h4000) | 16'h1000);
        chk(gap_bad == 0, "R5", "idle gap before status polls", gap_bad, 0);
        chk(r1_reads == exp_r1, exp_code == 2'b01 ? "R8" : "R6", "status reads", r1_reads, exp_r1);
        chk(link_up == exp_ok, "R6", "link_up", link_up, exp_ok);
        chk(init_done == exp_ok && r5_reads == (exp_ok ? 1 : 0), "R7", "init_done and partner reads",
            r5_reads, exp_ok);
        if (exp_ok) chk(partner_abil == p, "R7", "partner ability", partner_abil, p);
        chk(err == !exp_ok && err_code == exp_code, "R8", "error flag and code",
            {err, err_code}, {!exp_ok, exp_code});
        chk(other_acc == 0, "R2", "unexpected accesses", other_acc, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!cmd_req && !link_up && !init_done && !err && err_code == 2'b00, "R1",
            "outputs in reset", {cmd_req, link_up, init_done, err, err_code}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_req && !link_up && !init_done && !err, "R1", "outputs after reset",
            {cmd_req, link_up, init_done, err}, 0);
        chk(mdc_div == 8'd224, "R1", "divisor", mdc_div, 224);

        // directed corner cases
        run_seq(1, 1, 0, 16'h4000, 16'hC1E1, 5'd3, 0);                 // R4 bit14 only
        run_seq(MAX_POLLS, MAX_POLLS, 2, 16'hFFFF, 16'h05E1, 5'd31, 0); // R5 R6 last poll
        run_seq(MAX_POLLS + 1, 1, 1, 16'h1140, 16'h0001, 5'd7, 0);      // R8 negotiation timeout
        run_seq(2, 1, 0, 16'h0000, 16'hABCD, 5'd0, 0);                  // R10 restart after error
        run_seq(1, MAX_POLLS + 1, 3, 16'h2100, 16'h1234, 5'd17, 0);     // R8 link timeout
        run_seq(3, 2, 1, 16'h5A5A, 16'h4DE1, 5'd9, 1);                  // R9 start while busy

        // constrained random runs
        for (int i = 0; i < 12; i++) begin
            run_seq(1 + int'($urandom_range(0, MAX_POLLS)), 1 + int'($urandom_range(0, MAX_POLLS)),
                    int'($urandom_range(0, 3)), 16'($urandom), 16'($urandom),
                    5'($urandom), bit'($urandom_range(0, 1)));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule